// File: doc/BRIEF.md
# Three-Bank Level Interrupt Aggregator

This block gathers 72 level-sensitive interrupt inputs into three banks: a small primary bank of 8 inputs and two secondary banks of 32 inputs each. Each bank has an enable mask. An input shows as pending only while it is asserted and its enable bit is set. Software reaches the block through a word-addressed register port with a single write strobe and a combinational read path. Enable registers are write-one-to-set, disable registers are write-one-to-clear, and the pending registers are read-only.

The primary pending word is the entry point for a handler. Its low byte holds the primary bank's own inputs. Two summary bits report activity in the secondary banks. Eleven shortcut bits copy selected secondary inputs directly, so a handler can find the commonest sources with one read. A shortcut source never raises its bank's summary bit. The summary and shortcut bits have no mask in the primary bank and are gated only by their own bank's enables.

One interrupt request output is raised whenever anything is pending. A second, fast interrupt output can follow the raw level of one input, which is chosen by index.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset, all enable masks read 0, the fast-interrupt control reads 0, and irq_o and fiq_o are low whatever the inputs do.
- R2: Writing 1s to an enable register sets those mask bits. Enable offsets are 0x10 for bank 1, 0x14 for bank 2 and 0x18 for bank 0. Zero bits leave the mask unchanged. Reading an enable offset returns the current mask.
- R3: Writing 1s to a disable register clears those mask bits. Disable offsets are 0x1C for bank 1, 0x20 for bank 2 and 0x24 for bank 0. Zero bits leave the mask unchanged. Disable offsets read as 0.
- R4: The pending word of bank 1 (offset 0x04) and of bank 2 (offset 0x08) is input AND mask. Bits 7:0 of the bank 0 pending word (offset 0x00) are bank 0 input AND mask.
- R5: Bank 0 pending bit 8 is set when bank 1 has a pending source that has no shortcut. Bit 9 does the same for bank 2.
- R6: Bank 0 pending bits 10..14 mirror bank 1 pending bits 7, 9, 10, 18, 19, in that order. Bits 15..20 mirror bank 2 pending bits 21, 22, 23, 24, 25, 30, in that order. Shortcut sources never set bit 8 or bit 9. Bits 31..21 read 0.
- R7: The bank 0 mask holds only bits 7:0. Writes to bits 8 and up of offset 0x18 or 0x24 are ignored and cannot mask any summary or shortcut bit.
- R8: irq_o is high exactly when some input is asserted and enabled.
- R9: The fast-interrupt control at offset 0x0C keeps bits 7:0 of a write. Bits 6:0 are the source index and bit 7 is the enable. Bits 31:8 read 0.
- R10: With the fast-interrupt enable set, fiq_o equals the raw level of the selected input, whatever that input's mask. Indices 0..31 select bank 1, 32..63 select bank 2 and 64..71 select bank 0. Indices 72..127 give 0. With the enable clear, fiq_o is 0.
- R11: Reads of unmapped offsets (0x28 and above) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_b0 | input | 8 | Bank 0 interrupt levels |
| src_b1 | input | 32 | Bank 1 interrupt levels |
| src_b2 | input | 32 | Bank 2 interrupt levels |
| reg_we | input | 1 | Write strobe, captured on the rising clock edge |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq_o | output | 1 | Interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The only state is the three masks and the fast-interrupt control byte. A wrong mask bit shows in the pending words and in irq_o in the cycle right after the write that set it, for as long as the matching input is held high. A wrong control byte shows on fiq_o the moment the selected input toggles. The bench drives inputs in many patterns so that each corrupted bit has a visible input behind it. Shortcut and summary faults appear only in the bank 0 word, so every vector compares that word against a value worked out by hand.

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        src_b0,
  input  logic [31:0]       src_b1,
  input  logic [31:0]       src_b2,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam logic [ADDR_W-1:0] A_PEND0 = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_PEND1 = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_PEND2 = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_FCTL  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_SET1  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_SET2  = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_SET0  = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_CLR1  = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] A_CLR2  = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_CLR0  = ADDR_W'(8'h24);
  localparam logic [31:0] SC1_MASK = 32'h000C_0680;
  localparam logic [31:0] SC2_MASK = 32'h43E0_0000;
  localparam int          NSRC     = 72;

  logic [7:0]  en0;
  logic [31:0] en1, en2;
  logic [7:0]  fctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en0  <= '0;
      en1  <= '0;
      en2  <= '0;
      fctl <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_SET0: en0  <= en0 | reg_wdata[7:0];
        A_CLR0: en0  <= en0 & ~reg_wdata[7:0];
        A_SET1: en1  <= en1 | reg_wdata;
        A_CLR1: en1  <= en1 & ~reg_wdata;
        A_SET2: en2  <= en2 | reg_wdata;
        A_CLR2: en2  <= en2 & ~reg_wdata;
        A_FCTL: fctl <= reg_wdata[7:0];
        default: ;
      endcase
    end
  end

  wire [7:0]  p0 = src_b0 & en0;
  wire [31:0] p1 = src_b1 & en1;
  wire [31:0] p2 = src_b2 & en2;
  wire [4:0]  sc1 = {p1[19], p1[18], p1[10], p1[9], p1[7]};
  wire [5:0]  sc2 = {p2[30], p2[25], p2[24], p2[23], p2[22], p2[21]};
  wire        sum1 = |(p1 & ~SC1_MASK);
  wire        sum2 = |(p2 & ~SC2_MASK);
  wire [31:0] pend0 = {11'd0, sc2, sc1, sum2, sum1, p0};

  assign irq_o = |pend0[20:0];

  wire [NSRC-1:0] raw_all = {src_b0, src_b2, src_b1};
  wire [6:0]      fidx    = fctl[6:0];
  assign fiq_o = fctl[7] && (int'(fidx) < NSRC) && raw_all[fidx];

  always_comb begin
    case (reg_addr)
      A_PEND0: reg_rdata = pend0;
      A_PEND1: reg_rdata = p1;
      A_PEND2: reg_rdata = p2;
      A_FCTL:  reg_rdata = {24'd0, fctl};
      A_SET0:  reg_rdata = {24'd0, en0};
      A_SET1:  reg_rdata = en1;
      A_SET2:  reg_rdata = en2;
      default: reg_rdata = '0;
    endcase
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (en0 == '0 && en1 == '0 && en2 == '0 && fctl == '0));

  a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_SET1) |=> ((en1 & $past(reg_wdata)) == $past(reg_wdata)));

  a_r3_clear_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_CLR2) |=> ((en2 & $past(reg_wdata)) == 32'd0));

  a_r5_summary_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    pend0[8] |-> (|(src_b1 & en1)));

  a_r8_irq_any_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (|{src_b0 & en0, src_b1 & en1, src_b2 & en2}));

  a_r10_fiq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !fctl[7] |-> !fiq_o);
endmodule

// File: tb/sim_irq_bank_ctrl.sv
module sim_irq_bank_ctrl;
  logic clk = 0, rst_n = 0;
  logic [7:0] src_b0 = 0;
  logic [31:0] src_b1 = 0, src_b2 = 0;
  logic reg_we = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq_o, fiq_o;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  irq_bank_ctrl #(.ADDR_W(8)) u0 (.*);

  // {src_b0, src_b1, src_b2, expected bank 0 pending word}
  localparam logic [103:0] VEC [9] = '{
    {8'h00, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
    {8'h81, 32'h0000_0000, 32'h0000_0000, 32'h0000_0081},
    {8'h00, 32'h0000_0001, 32'h0000_0000, 32'h0000_0100},
    {8'h00, 32'h0000_0080, 32'h0000_0000, 32'h0000_0400},
    {8'h00, 32'h0008_0001, 32'h0000_0000, 32'h0000_4100},
    {8'h00, 32'h0000_0000, 32'h4000_0000, 32'h0010_0000},
    {8'h00, 32'h0000_0000, 32'h8020_0000, 32'h0000_8200},
    {8'h00, 32'h0004_0600, 32'h0000_0000, 32'h0000_3800},
    {8'h10, 32'h0000_0000, 32'h03C0_0000, 32'h000F_0010}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r;
    src_b0 = 8'hFF; src_b1 = '1; src_b2 = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(8'h18, r); chk("R1 en0", r, 0);
    rd(8'h10, r); chk("R1 en1", r, 0);
    rd(8'h14, r); chk("R1 en2", r, 0);
    rd(8'h0C, r); chk("R1 fctl", r, 0);
    rd(8'h00, r); chk("R1 pend0", r, 0);
    chk("R1 irq", {31'd0, irq_o}, 0);
    chk("R1 fiq", {31'd0, fiq_o}, 0);

    wr(8'h18, 32'hFF); wr(8'h10, '1); wr(8'h14, '1);
    for (int i = 0; i < 9; i++) begin
      src_b0 = VEC[i][103:96]; src_b1 = VEC[i][95:64]; src_b2 = VEC[i][63:32];
      rd(8'h00, r); chk("R5/R6 pend0 vector", r, VEC[i][31:0]);
      rd(8'h04, r); chk("R4 pend1 vector", r, VEC[i][95:64]);
      rd(8'h08, r); chk("R4 pend2 vector", r, VEC[i][63:32]);
      chk("R8 irq vector", {31'd0, irq_o}, {31'd0, VEC[i][31:0] != 0});
    end

    wr(8'h10, 32'hFFFF_FFFF); wr(8'h1C, '1); wr(8'h14, '1); wr(8'h20, '1); wr(8'h24, '1);
    wr(8'h10, 32'h0000_00F0);
    rd(8'h10, r); chk("R2 set", r, 32'h0000_00F0);
    wr(8'h10, 32'h0000_0000);
    rd(8'h10, r); chk("R2 zero write", r, 32'h0000_00F0);
    wr(8'h10, 32'h8000_0001);
    rd(8'h10, r); chk("R2 accumulate", r, 32'h8000_00F1);
    wr(8'h1C, 32'h0000_0030);
    rd(8'h10, r); chk("R3 clear", r, 32'h8000_00C1);
    wr(8'h1C, 32'h0);
    rd(8'h10, r); chk("R3 zero write", r, 32'h8000_00C1);
    rd(8'h1C, r); chk("R3 reads zero", r, 0);
    src_b1 = 32'h0000_0030; src_b0 = 0; src_b2 = 0;
    rd(8'h04, r); chk("R4 masked", r, 0);
    chk("R8 irq masked", {31'd0, irq_o}, 0);
    src_b1 = 32'h0000_0040;
    rd(8'h04, r); chk("R4 enabled", r, 32'h0000_0040);
    rd(8'h00, r); chk("R5 summary", r, 32'h0000_0100);

    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, r); chk("R7 en0 width", r, 32'hFF);
    wr(8'h10, 32'h0000_0080); src_b1 = 32'h0000_0080;
    wr(8'h24, 32'hFFFF_FF00);
    rd(8'h18, r); chk("R7 upper disable ignored", r, 32'hFF);
    rd(8'h00, r); chk("R7 shortcut unmaskable", r, 32'h0000_0400);
    chk("R8 irq shortcut", {31'd0, irq_o}, 1);

    wr(8'h0C, 32'hFFFF_FF05);
    rd(8'h0C, r); chk("R9 fctl", r, 32'h05);
    src_b1 = 32'h0000_0020;
    chk("R10 disabled", {31'd0, fiq_o}, 0);
    wr(8'h0C, 32'h85);
    src_b1 = 32'h0000_0020; #1;
    chk("R10 bank1 idx5 high", {31'd0, fiq_o}, 1);
    src_b1 = 0; #1;
    chk("R10 bank1 idx5 low", {31'd0, fiq_o}, 0);
    wr(8'h0C, 32'h80 | 40); src_b2 = 32'h0000_0100; #1;
    chk("R10 bank2 idx40", {31'd0, fiq_o}, 1);
    wr(8'h0C, 32'h80 | 66); src_b2 = 0; src_b0 = 8'h04; #1;
    chk("R10 bank0 idx66", {31'd0, fiq_o}, 1);
    src_b0 = 8'hFB; #1;
    chk("R10 bank0 idx66 low", {31'd0, fiq_o}, 0);
    wr(8'h0C, 32'h80 | 100); src_b0 = '1; src_b1 = '1; src_b2 = '1; #1;
    chk("R10 idx out of range", {31'd0, fiq_o}, 0);

    rd(8'h28, r); chk("R11 unmapped 0x28", r, 0);
    rd(8'h3C, r); chk("R11 unmapped 0x3C", r, 0);
    rd(8'hFC, r); chk("R11 unmapped 0xFC", r, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule